// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Deferred Completion

This block serializes one byte at a time onto a single output line. The frame is either 8-bit or 9-bit. Every frame opens with a low start bit, sends its data bits least-significant first, may carry a ninth bit, and closes with one high stop bit. Bit timing comes from an external `bitTick` pulse, one clock wide, given once per bit time. The line rests high whenever no frame is running.

The ninth bit is written by software. In the 9-bit parity format with parity on, the block replaces it with a computed parity bit. Either way it is cleared once the frame completes, so software has to rewrite it before every frame. In the 8-bit format with parity on, the top data bit carries the parity of the lower seven bits. The completion event sets a sticky done flag, pulses an interrupt request and reopens the buffer. It can happen as the stop bit begins, or 1, 3 or 7 bit times later. Changing the format selection cancels a running frame at once.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `bufEmpty` is 1, `txDone` is 0, `txIrq` is 0 and `ninthBit` is 0.
- R2: In format `modeSel`=01, an accepted write followed by ticks produces these `txd` values, one per tick starting with the first tick after the write: 0, then data bits 0 to 7, then 1. `txd` changes only on a tick or on a cancel.
- R3: In format 01 with `parEn`=1, data bit 7 is replaced by the parity of bits 6:0. `parOdd`=0 makes the count of ones in the 8 sent bits even, and `parOdd`=1 makes it odd.
- R4: In format 10 the frame is start, 8 data bits, `ninthBit`, stop. `ninthBit` is loaded by `ninthWr`/`ninthIn` and reads 0 after each completion.
- R5: In format 11 with `parEn`=1, the ninth bit sent is the parity of the 8 data bits. It is even when `parOdd`=0 and odd when `parOdd`=1, and `ninthBit` holds this value while the frame runs.
- R6: With `dlySel`=00, completion happens on the same tick that puts the stop bit on `txd`. From that cycle `bufEmpty` is 1 and `txDone` is 1, and `txIrq` is 1 for exactly that one cycle.
- R7: With `dlySel` set to 01, 10 or 11, completion happens on the 1st, 3rd or 7th tick after the stop-bit tick, and `bufEmpty` stays 0 until then.
- R8: A data write while `bufEmpty` is 0 is ignored. The running frame continues unchanged.
- R9: Any change of `modeSel` cancels a running frame. The next cycle shows `txd`=1 and `bufEmpty`=1, and no completion follows.
- R10: While `modeSel`=00 the transmitter is off: data writes are ignored, `bufEmpty` stays 1 and `txd` stays 1.
- R11: `doneClr` clears `txDone`. `txIrq` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse marking each bit time |
| modeSel | input | 2 | Frame format: 00 off, 01 8-bit, 10 9-bit, 11 9-bit with parity |
| parEn | input | 1 | Parity enable (formats 01 and 11) |
| parOdd | input | 1 | Parity sense: 0 even, 1 odd |
| dlySel | input | 2 | Completion delay: 0, 1, 3 or 7 bit times |
| ninthWr | input | 1 | Strobe that loads the software ninth bit |
| ninthIn | input | 1 | Value for the software ninth bit |
| dataWr | input | 1 | Strobe that starts a frame with `dataIn` |
| dataIn | input | 8 | Byte to send |
| doneClr | input | 1 | Clears the sticky done flag |
| txd | output | 1 | Serial line, idles high |
| bufEmpty | output | 1 | High when a new byte is accepted |
| txDone | output | 1 | Sticky completion flag |
| txIrq | output | 1 | One-cycle completion pulse |
| ninthBit | output | 1 | Current ninth-bit register |

## Verification
The bench counts ticks from the write to the exact completion tick for every delay setting. A design that counted the delay from the frame start or from the end of the stop bit would raise `bufEmpty` one or more ticks early or late. Parity is checked with odd and even senses on bytes chosen so that the two results differ. In the 9-bit formats the bench sends a second frame without rewriting the ninth bit, which exposes a design that leaves the bit set. It also writes while a frame is running and changes the format mid-frame. A design that accepted the busy write would corrupt the serial bits, and a design that finished the cancelled frame would leave the line low or raise the done flag.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_8B      = 2'b01,
    MODE_9B_ADDR = 2'b10,
    MODE_9B_PAR  = 2'b11
  } txMode_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic abort;
    logic clrNinth;
  } txStrb_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic [1:0]       modeSel,
  input  logic [DLY_W-1:0] dlySel,
  input  logic             dataWr,
  input  logic             doneClr,
  output txStrb_t          strb,
  output logic             bufEmpty,
  output logic             txDone,
  output logic             txIrq
);
  localparam int MAX_DLY = (1 << ((1 << DLY_W) - 1)) - 1;
  localparam int MAX_END = DATA_W + 3 + MAX_DLY;
  localparam int CNT_W   = $clog2(MAX_END + 1);

  logic [1:0]       modePrev;
  logic             busy;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] endCnt;
  logic [CNT_W-1:0] dlyTicks;
  logic [CNT_W-1:0] frameLen;
  logic [CNT_W-1:0] cntNext;
  logic             finishNow;

  always_comb begin
    dlyTicks  = CNT_W'((32'd1 << dlySel) - 32'd1);
    frameLen  = modeSel[1] ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);
    cntNext   = tickCnt + CNT_W'(1);
    strb.abort    = (modeSel != modePrev);
    strb.load     = dataWr && !busy && (modeSel != MODE_OFF) && !strb.abort;
    strb.shift    = busy && bitTick && !strb.abort;
    finishNow     = strb.shift && (cntNext == endCnt);
    strb.clrNinth = finishNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePrev <= MODE_OFF;
      busy     <= 1'b0;
      tickCnt  <= '0;
      endCnt   <= '0;
      txIrq    <= 1'b0;
      txDone   <= 1'b0;
    end else begin
      modePrev <= modeSel;
      txIrq    <= finishNow;
      if (strb.abort) begin
        busy    <= 1'b0;
        tickCnt <= '0;
      end else if (strb.load) begin
        busy    <= 1'b1;
        tickCnt <= '0;
        endCnt  <= frameLen + dlyTicks;
      end else if (strb.shift) begin
        tickCnt <= cntNext;
        if (finishNow) busy <= 1'b0;
      end
      if (finishNow)    txDone <= 1'b1;
      else if (doneClr) txDone <= 1'b0;
    end
  end

  assign bufEmpty = !busy;

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);
  assert_irq_reopens_R6: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (bufEmpty && txDone));
  assert_abort_frees_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (bufEmpty && !txIrq));
endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrb_t           strb,
  input  logic [1:0]        modeSel,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              ninthWr,
  input  logic              ninthIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              txd,
  output logic              ninthBit
);
  localparam int FRAME_W = DATA_W + 3;

  logic [FRAME_W-1:0] shReg;
  logic [FRAME_W-1:0] frameWord;
  logic [DATA_W-1:0]  payload;
  logic               txdReg;
  logic               ninthReg;
  logic               lowPar;
  logic               fullPar;
  logic               ninthSend;
  logic               parNinth;

  always_comb begin
    lowPar    = (^dataIn[DATA_W-2:0]) ^ parOdd;
    fullPar   = (^dataIn) ^ parOdd;
    parNinth  = (modeSel == MODE_9B_PAR) && parEn;
    ninthSend = parNinth ? fullPar : ninthReg;
    payload   = ((modeSel == MODE_8B) && parEn) ? {lowPar, dataIn[DATA_W-2:0]} : dataIn;
    frameWord = modeSel[1] ? {1'b1, ninthSend, payload, 1'b0}
                           : {2'b11, payload, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '1;
      txdReg   <= 1'b1;
      ninthReg <= 1'b0;
    end else begin
      if (strb.abort) begin
        shReg  <= '1;
        txdReg <= 1'b1;
      end else if (strb.load) begin
        shReg  <= frameWord;
      end else if (strb.shift) begin
        txdReg <= shReg[0];
        shReg  <= {1'b1, shReg[FRAME_W-1:1]};
      end
      if (strb.load && parNinth) ninthReg <= fullPar;
      else if (ninthWr)          ninthReg <= ninthIn;
      else if (strb.clrNinth)    ninthReg <= 1'b0;
    end
  end

  assign txd      = txdReg;
  assign ninthBit = ninthReg;

  assert_abort_line_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> txd);
  assert_ninth_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrNinth && !ninthWr) |=> !ninthBit);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [1:0]        modeSel,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic [DLY_W-1:0]  dlySel,
  input  logic              ninthWr,
  input  logic              ninthIn,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              doneClr,
  output logic              txd,
  output logic              bufEmpty,
  output logic              txDone,
  output logic              txIrq,
  output logic              ninthBit
);
  txStrb_t strb;

  sertx_ctrl #(.DATA_W(DATA_W), .DLY_W(DLY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .modeSel(modeSel),
    .dlySel(dlySel), .dataWr(dataWr), .doneClr(doneClr), .strb(strb),
    .bufEmpty(bufEmpty), .txDone(txDone), .txIrq(txIrq)
  );

  sertx_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .modeSel(modeSel), .parEn(parEn),
    .parOdd(parOdd), .ninthWr(ninthWr), .ninthIn(ninthIn), .dataIn(dataIn),
    .txd(txd), .ninthBit(ninthBit)
  );

  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> txd);
  assert_txd_on_tick_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !strb.abort) |=> $stable(txd));
endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       parEn = 1'b0;
  logic       parOdd = 1'b0;
  logic [1:0] dlySel = 2'b00;
  logic       ninthWr = 1'b0;
  logic       ninthIn = 1'b0;
  logic       dataWr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       doneClr = 1'b0;
  logic       txd, bufEmpty, txDone, txIrq, ninthBit;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  sertx_top dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .modeSel(modeSel), .parEn(parEn),
    .parOdd(parOdd), .dlySel(dlySel), .ninthWr(ninthWr), .ninthIn(ninthIn),
    .dataWr(dataWr), .dataIn(dataIn), .doneClr(doneClr), .txd(txd),
    .bufEmpty(bufEmpty), .txDone(txDone), .txIrq(txIrq), .ninthBit(ninthBit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk); bitTick = 1'b1;
    @(negedge clk); bitTick = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); modeSel = m;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); dataIn = d; dataWr = 1'b1;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic clearDone();
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
  endtask

  // Sends a frame and follows it tick by tick up to the completion point.
  task automatic runFrame(input string tag, input logic [7:0] d, input int len,
                          input logic [10:0] exp, input int dv);
    clearDone();
    writeByte(d);
    check({tag, " busy after write"}, bufEmpty, 1'b0);
    for (int k = 0; k < len; k++) begin
      tick();
      check({tag, " txd bit"}, txd, exp[k]);
      check({tag, " bufEmpty during frame"}, bufEmpty, (k == len - 1) && (dv == 0));
    end
    for (int j = 1; j <= dv; j++) begin
      tick();
      check({tag, " R7 bufEmpty in delay"}, bufEmpty, j == dv);
      check({tag, " R7 txd idle in delay"}, txd, 1'b1);
    end
    check({tag, " R6 txIrq at completion"}, txIrq, 1'b1);
    check({tag, " R6 txDone set"}, txDone, 1'b1);
    @(negedge clk);
    check({tag, " R11 txIrq one cycle"}, txIrq, 1'b0);
  endtask

  function automatic logic [10:0] frame8(input logic [7:0] d);
    return {2'b11, d, 1'b0};
  endfunction

  function automatic logic [10:0] frame9(input logic [7:0] d, input logic n);
    return {1'b1, n, d, 1'b0};
  endfunction

  task automatic testReset();
    check("R1 txd", txd, 1'b1);
    check("R1 bufEmpty", bufEmpty, 1'b1);
    check("R1 txDone", txDone, 1'b0);
    check("R1 txIrq", txIrq, 1'b0);
    check("R1 ninthBit", ninthBit, 1'b0);
  endtask

  task automatic testPlain8();
    setMode(2'b01); parEn = 1'b0; dlySel = 2'b00;
    runFrame("R2 R6 8-bit A5", 8'hA5, 10, frame8(8'hA5), 0);
    runFrame("R2 8-bit 3C", 8'h3C, 10, frame8(8'h3C), 0);
    clearDone();
    check("R11 doneClr clears txDone", txDone, 1'b0);
  endtask

  task automatic testPar8();
    parEn = 1'b1; parOdd = 1'b0;
    runFrame("R3 even 7F", 8'h7F, 10, frame8(8'hFF), 0);
    parOdd = 1'b1;
    runFrame("R3 odd 7F", 8'h7F, 10, frame8(8'h7F), 0);
    runFrame("R3 odd 81", 8'h81, 10, frame8(8'h01), 0);
    parEn = 1'b0; parOdd = 1'b0;
  endtask

  task automatic testNinth();
    setMode(2'b10);
    @(negedge clk); ninthWr = 1'b1; ninthIn = 1'b1;
    @(negedge clk); ninthWr = 1'b0;
    check("R4 ninthBit written", ninthBit, 1'b1);
    runFrame("R4 ninth set", 8'h3C, 11, frame9(8'h3C, 1'b1), 0);
    check("R4 ninthBit cleared", ninthBit, 1'b0);
    runFrame("R4 ninth not rewritten", 8'h3C, 11, frame9(8'h3C, 1'b0), 0);
  endtask

  task automatic testPar9();
    setMode(2'b11); parEn = 1'b1; parOdd = 1'b0;
    clearDone();
    writeByte(8'h07);
    check("R5 even parity in ninthBit", ninthBit, 1'b1);
    for (int k = 0; k < 11; k++) begin
      tick();
      check("R5 even frame bit", txd, frame9(8'h07, 1'b1)[k]);
    end
    check("R5 ninthBit cleared", ninthBit, 1'b0);
    parOdd = 1'b1;
    runFrame("R5 odd 07", 8'h07, 11, frame9(8'h07, 1'b0), 0);
    runFrame("R5 odd 0F", 8'h0F, 11, frame9(8'h0F, 1'b1), 0);
    parEn = 1'b0; parOdd = 1'b0;
  endtask

  task automatic testDelays();
    setMode(2'b01);
    dlySel = 2'b01; runFrame("R7 delay1", 8'h96, 10, frame8(8'h96), 1);
    dlySel = 2'b10; runFrame("R7 delay3", 8'h69, 10, frame8(8'h69), 3);
    dlySel = 2'b11; runFrame("R7 delay7", 8'hC3, 10, frame8(8'hC3), 7);
    setMode(2'b10);
    dlySel = 2'b10; runFrame("R7 delay3 9-bit", 8'h5A, 11, frame9(8'h5A, 1'b0), 3);
    dlySel = 2'b00;
  endtask

  task automatic testBusyWrite();
    setMode(2'b01); dlySel = 2'b01;
    clearDone();
    writeByte(8'h55);
    for (int k = 0; k < 10; k++) begin
      if (k == 3) writeByte(8'hFF);
      tick();
      check("R8 frame kept during busy write", txd, frame8(8'h55)[k]);
    end
    check("R8 buffer still closed at stop", bufEmpty, 1'b0);
    tick();
    check("R8 buffer opens at delayed point", bufEmpty, 1'b1);
    check("R8 line idle after frame", txd, 1'b1);
    dlySel = 2'b00;
  endtask

  task automatic testAbort();
    setMode(2'b01);
    clearDone();
    writeByte(8'h00);
    for (int k = 0; k < 4; k++) tick();
    check("R9 line low before cancel", txd, 1'b0);
    @(negedge clk); modeSel = 2'b11;
    @(negedge clk);
    check("R9 txd high after cancel", txd, 1'b1);
    check("R9 bufEmpty after cancel", bufEmpty, 1'b1);
    for (int k = 0; k < 10; k++) tick();
    check("R9 no completion after cancel", txDone, 1'b0);
    check("R9 line stays idle", txd, 1'b1);
  endtask

  task automatic testOff();
    setMode(2'b00);
    writeByte(8'h00);
    check("R10 write ignored when off", bufEmpty, 1'b1);
    tick();
    check("R10 line idle when off", txd, 1'b1);
    tick();
    check("R10 no done when off", txDone, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain8();
    testPar8();
    testNinth();
    testPar9();
    testDelays();
    testBusyWrite();
    testAbort();
    testOff();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule